// File: doc/BRIEF.md
# Zoom Converter Coarse-Fine Output Combiner

This block builds the full-rate digital output of a zoom converter. Each cycle that the sample strobe is high it takes the coarse successive-approximation code and the one-bit modulator decision. It returns one signed fixed-point sample one cycle later. The coarse code is not added to the output directly. It first runs through an eight-tap FIR whose programmable coefficients are set to match the modulator's signal transfer function. This shaping removes the out-of-band residue that is left when the coarse quantization error cancels imperfectly.

The modulator decision is mapped to the contribution of the fine DAC step. A one adds two coarse LSBs and a zero subtracts one coarse LSB. The decision is delayed by a fixed number of samples so that it lines up with the group delay of the FIR, and is then summed with the filtered coarse term. A bypass input swaps the filtered term for the plain current code plus the undelayed mapped decision. Decimation is left to a later stage.

Top module: `zoom_combiner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `outValid` is 0 and `outSample` is 0.
- R2: `outValid` is 1 exactly in the cycle after a cycle with `inValid` high, and 0 otherwise.
- R3: In filtered mode the output is sum over i=0..7 of coef[i]·K(n−i) plus the delayed decision term. K(n−i) is the clamped code of the i-th earlier valid sample. The coefficients and the output carry FRAC=10 fractional bits. History that is not yet filled counts as code 0.
- R4: A decision bit of 1 contributes +2·2^FRAC and a bit of 0 contributes −1·2^FRAC.
- R5: In filtered mode the decision used is the one given BS_DELAY=4 valid samples earlier. Decisions before the first sample after reset count as 0.
- R6: Codes below 1 are treated as 1 and codes above 29 as 29, both in the output and in the stored history.
- R7: With `bypass` high, the output is clamped K·2^FRAC plus the mapped current decision, so its fractional bits are zero. The history keeps advancing in this mode.
- R8: The accumulator is wide enough that no output can exceed 8·2^11·29 + 2·2^FRAC in magnitude, and the output never wraps.
- R9: Cycles without `inValid` neither change `outSample` nor advance the code or decision history.
- R10: A coefficient write (`coefWe`, `coefIdx`, 12-bit signed `coefData`) applies from the next sample onward. Reset sets tap 0 to 1.0 (1024) and the other taps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe for coarseCode and bitIn |
| coarseCode | input | 5 | Coarse code K, unsigned |
| bitIn | input | 1 | Modulator decision |
| bypass | input | 1 | 1: unfiltered sum, 0: filtered path |
| coefWe | input | 1 | Coefficient write enable |
| coefIdx | input | 3 | Tap index to write |
| coefData | input | 12 | Signed coefficient, 10 fractional bits |
| outValid | output | 1 | Output sample strobe |
| outSample | output | 23 | Signed output, 10 fractional bits |

## Verification
The assertions assume that `inValid`, `bypass` and the coefficient port are driven low during reset. They also assume that coefficients stay inside their 12-bit signed range, which the port width enforces. The stimulus changes inputs only on the falling clock edge and releases reset there. It writes coefficients only between samples, never in the same cycle as a strobe, so every write falls between two samples. The bound in R8 also assumes that only clamped codes reach the multipliers. For that reason the stimulus includes out-of-range codes 0, 30 and 31, to show that the clamp keeps the products inside the bound.

// File: rtl/zc_pkg.sv
package zc_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic shift;      // advance code and decision history
    logic capture;    // load output register
    logic useBypass;  // select unfiltered sum
    logic coefWrite;  // update one coefficient
  } zcStrobes_t;
endpackage

// File: rtl/zc_ctrl.sv
module zc_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                bypass,
  input  logic                coefWe,
  output zc_pkg::zcStrobes_t  strb,
  output logic                outValid
);
  always_comb begin
    strb.shift     = inValid;
    strb.capture   = inValid;
    strb.useBypass = bypass;
    strb.coefWrite = coefWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: valid strobe follows the input strobe by one cycle
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/zc_datapath.sv
module zc_datapath #(
  parameter int TAPS     = 8,
  parameter int K_W      = 5,
  parameter int K_MIN    = 1,
  parameter int K_MAX    = 29,
  parameter int COEF_W   = 12,
  parameter int FRAC     = 10,
  parameter int BS_DELAY = 4,
  parameter int ACC_W    = 23,
  parameter int IDX_W    = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  zc_pkg::zcStrobes_t        strb,
  input  logic [K_W-1:0]            coarseCode,
  input  logic                      bitIn,
  input  logic [IDX_W-1:0]          coefIdx,
  input  logic signed [COEF_W-1:0]  coefData,
  output logic signed [ACC_W-1:0]   outSample
);
  localparam int PROD_W  = COEF_W + K_W + 1;
  localparam int BS_HI_I = 2 * (1 << FRAC);
  localparam int BS_LO_I = -(1 << FRAC);
  localparam int MAX_ABS = TAPS * (1 << (COEF_W - 1)) * K_MAX + BS_HI_I;
  localparam logic signed [ACC_W-1:0] BS_HI = ACC_W'(BS_HI_I);
  localparam logic signed [ACC_W-1:0] BS_LO = ACC_W'(BS_LO_I);

  // input clamp
  logic [K_W-1:0] codeClamped;
  always_comb begin
    if (coarseCode < K_W'(K_MIN))      codeClamped = K_W'(K_MIN);
    else if (coarseCode > K_W'(K_MAX)) codeClamped = K_W'(K_MAX);
    else                               codeClamped = coarseCode;
  end

  // code history and window
  logic [K_W-1:0] codeHist [TAPS-1];
  logic [K_W-1:0] window   [TAPS];
  assign window[0] = codeClamped;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS - 1; gi++) begin : g_hist
      assign window[gi+1] = codeHist[gi];
      always_ff @(posedge clk) begin
        if (!rstN)           codeHist[gi] <= '0;
        else if (strb.shift) codeHist[gi] <= window[gi];
      end
    end
  endgenerate

  // coefficient registers, reset to a unit impulse
  logic signed [COEF_W-1:0] coefReg [TAPS];
  logic signed [PROD_W-1:0] prod    [TAPS];

  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      localparam logic signed [COEF_W-1:0] COEF_RST =
        (gi == 0) ? COEF_W'(1 << FRAC) : '0;
      always_ff @(posedge clk) begin
        if (!rstN)
          coefReg[gi] <= COEF_RST;
        else if (strb.coefWrite && coefIdx == IDX_W'(gi))
          coefReg[gi] <= coefData;
      end
      assign prod[gi] = coefReg[gi] * $signed({1'b0, window[gi]});
    end
  endgenerate

  logic signed [ACC_W-1:0] firSum;
  always_comb begin
    firSum = '0;
    for (int i = 0; i < TAPS; i++) firSum = firSum + ACC_W'(prod[i]);
  end

  // decision alignment
  logic bsAligned;
  generate
    if (BS_DELAY == 0) begin : g_nodly
      assign bsAligned = bitIn;
    end else begin : g_dly
      logic [BS_DELAY-1:0] bsLine;
      always_ff @(posedge clk) begin
        if (!rstN) bsLine <= '0;
        else if (strb.shift) begin
          bsLine[0] <= bitIn;
          for (int j = 1; j < BS_DELAY; j++) bsLine[j] <= bsLine[j-1];
        end
      end
      assign bsAligned = bsLine[BS_DELAY-1];
    end
  endgenerate

  logic signed [ACC_W-1:0] bsTermFilt, bsTermNow, coarseDirect, result;
  always_comb begin
    bsTermFilt   = bsAligned ? BS_HI : BS_LO;
    bsTermNow    = bitIn ? BS_HI : BS_LO;
    coarseDirect = $signed(ACC_W'(codeClamped) << FRAC);
    result       = strb.useBypass ? (coarseDirect + bsTermNow)
                                  : (firSum + bsTermFilt);
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outSample <= '0;
    else if (strb.capture) outSample <= result;
  end

  // R6: only in-range codes reach the multipliers
  assert_clamp_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> (codeClamped >= K_W'(K_MIN) && codeClamped <= K_W'(K_MAX)));
  // R9: output holds between samples
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(outSample));
  // R8: the output stays inside the analytical bound
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(outSample) <= MAX_ABS) && (int'(outSample) >= -MAX_ABS));
endmodule

// File: rtl/zoom_combiner.sv
module zoom_combiner #(
  parameter int TAPS     = 8,
  parameter int K_W      = 5,
  parameter int COEF_W   = 12,
  parameter int FRAC     = 10,
  parameter int BS_DELAY = 4,
  parameter int IDX_W    = $clog2(TAPS),
  parameter int ACC_W    = COEF_W + K_W + 1 + IDX_W + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [K_W-1:0]            coarseCode,
  input  logic                      bitIn,
  input  logic                      bypass,
  input  logic                      coefWe,
  input  logic [IDX_W-1:0]          coefIdx,
  input  logic signed [COEF_W-1:0]  coefData,
  output logic                      outValid,
  output logic signed [ACC_W-1:0]   outSample
);
  zc_pkg::zcStrobes_t strb;

  zc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bypass   (bypass),
    .coefWe   (coefWe),
    .strb     (strb),
    .outValid (outValid)
  );

  zc_datapath #(
    .TAPS     (TAPS),
    .K_W      (K_W),
    .K_MIN    (1),
    .K_MAX    (29),
    .COEF_W   (COEF_W),
    .FRAC     (FRAC),
    .BS_DELAY (BS_DELAY),
    .ACC_W    (ACC_W),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .coarseCode (coarseCode),
    .bitIn      (bitIn),
    .coefIdx    (coefIdx),
    .coefData   (coefData),
    .outSample  (outSample)
  );

  // R7: bypass samples are whole coarse LSBs
  assert_bypass_integer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bypass) |=> (outSample[FRAC-1:0] == '0));
endmodule

// File: tb/zoom_combiner_tb_top.sv
module zoom_combiner_tb_top;
  localparam int FRAC = 10;
  localparam int LSB  = 1 << FRAC;
  localparam int NVEC = 16;
  // stimulus table: {code[4:0], bit}
  localparam logic [5:0] STIM [NVEC] = '{
    {5'd12, 1'b1}, {5'd13, 1'b0}, {5'd29, 1'b1}, {5'd1,  1'b0},
    {5'd0,  1'b1}, {5'd31, 1'b1}, {5'd30, 1'b0}, {5'd15, 1'b0},
    {5'd16, 1'b1}, {5'd20, 1'b1}, {5'd7,  1'b0}, {5'd25, 1'b1},
    {5'd29, 1'b1}, {5'd29, 1'b1}, {5'd2,  1'b0}, {5'd18, 1'b1}
  };
  localparam int COEFS [8] = '{-40, 90, 310, 700, -2048, 2047, 120, -60};

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, bitIn = 1'b0, bypass = 1'b0;
  logic coefWe = 1'b0;
  logic [4:0] coarseCode = '0;
  logic [2:0] coefIdx = '0;
  logic signed [11:0] coefData = '0;
  logic outValid;
  logic signed [22:0] outSample;

  int total = 0, bad = 0;
  int mCoef [8];
  int mK [8];
  int mB [5];

  always #5 clk = ~clk;

  zoom_combiner dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coarseCode(coarseCode),
    .bitIn(bitIn), .bypass(bypass), .coefWe(coefWe), .coefIdx(coefIdx),
    .coefData(coefData), .outValid(outValid), .outSample(outSample)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) begin mCoef[i] = (i == 0) ? LSB : 0; mK[i] = 0; end
    for (int i = 0; i < 5; i++) mB[i] = 0;
  endtask

  function automatic int bsVal(input int b);
    return b ? 2 * LSB : -LSB;
  endfunction

  task automatic writeCoef(input int idx, input int val);
    coefWe = 1'b1; coefIdx = 3'(idx); coefData = 12'(val);
    @(negedge clk);
    coefWe = 1'b0;
    mCoef[idx] = val;
  endtask

  // called at a falling edge; checks on the next falling edge
  task automatic sendSample(input int k, input int b, input int byp, input string req);
    int kc, exp;
    kc = (k < 1) ? 1 : ((k > 29) ? 29 : k);
    for (int i = 7; i > 0; i--) mK[i] = mK[i-1];
    mK[0] = kc;
    for (int i = 4; i > 0; i--) mB[i] = mB[i-1];
    mB[0] = b;
    if (byp != 0) exp = kc * LSB + bsVal(b);
    else begin
      exp = bsVal(mB[4]);
      for (int i = 0; i < 8; i++) exp += mCoef[i] * mK[i];
    end
    coarseCode = 5'(k); bitIn = b[0]; bypass = byp[0]; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R2 outValid", int'(outValid), 1);
    chk(req, int'(outSample), exp);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int held;
    modelReset();
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", int'(outValid), 0);
    chk("R1 outSample in reset", int'(outSample), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", int'(outValid), 0);
    chk("R1 outSample after reset", int'(outSample), 0);

    // R10 default impulse coefficients, R5 decision history starts at 0
    sendSample(10, 1, 0, "R10 default coefs");

    for (int i = 0; i < 8; i++) writeCoef(i, COEFS[i]);

    // R3 R4 R5 R6: table walk, back to back
    for (int v = 0; v < NVEC; v++)
      sendSample(int'(STIM[v][5:1]), int'(STIM[v][0]), 0, "R3 filtered sample");

    // R9: idle cycles hold output
    held = int'(outSample);
    repeat (3) begin
      @(negedge clk);
      chk("R2 no strobe", int'(outValid), 0);
      chk("R9 hold", int'(outSample), held);
    end
    sendSample(9, 0, 0, "R9 history after gap");

    // R7 bypass with R6 clamp and R4 mapping
    sendSample(17, 1, 1, "R7 bypass bit1");
    sendSample(5, 0, 1, "R7 bypass bit0");
    sendSample(0, 1, 1, "R6 bypass clamp low");
    sendSample(31, 0, 1, "R6 bypass clamp high");
    sendSample(22, 1, 0, "R7 history advanced in bypass");

    // R10 coefficient rewrite mid-stream
    writeCoef(3, -1);
    sendSample(11, 0, 0, "R10 rewrite applies");

    // R1 R10 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 outSample reset mid-run", int'(outSample), 0);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
    sendSample(3, 0, 0, "R10 coefs restored");
    sendSample(4, 1, 0, "R5 decisions cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule